// File: doc/BRIEF.md
# Circular Capture Sequencer with Post-Trigger Count

This block runs the store side of a sampling logic analyzer. After an initialize pulse it waits idle. An arm request starts a capture session. In that session every sample strobe writes one byte into a circular sample memory and moves the write address up by one. The address wraps at the top of the memory and keeps running for as long as the session lasts.

When the trigger qualifier first reports a hit on a stored sample, a countdown is loaded. Its length comes from a 3-bit length select. Once that many further bytes have been stored, the session closes by itself. A manual stop input closes the session at once, whatever the countdown holds. The active-low busy status stays low for exactly as long as the session is open.

After the session, the address of the last stored byte stays on a dedicated port. Host software uses it to locate the trigger point. With the active-low read select asserted, the memory address switches to a read pointer. The host steps that pointer with rising edges of a read strobe.

Top module: `capctl`

## Requirements
- R1: After `init` is high for one clock edge, `write_n` is 1, `mem_we` is 0, `mem_addr` is 0 with `read_n` high, and `last_addr` is 0. `init` takes priority over every other input.
- R2: `arm` high while idle opens a capture session, so `write_n` reads 0 after that clock edge. `arm` is ignored once a session has ended, until the next `init`.
- R3: During a session, `mem_we` follows `smp_en` in the same cycle and `mem_addr` shows the write address. Each write advances the address by one after the edge, and the address wraps from 32767 to 0.
- R4: `mem_we` is never 1 while `write_n` is 1.
- R5: The first stored sample with `trig` high is followed by exactly N more writes, and then `write_n` returns to 1. N comes from the length select: 3'd0 gives 1, 3'd1 gives 16, 3'd2 gives 64, 3'd3 gives 256, 3'd4 gives 1024, 3'd5 gives 4096, 3'd6 gives 16384 and 3'd7 gives 32767.
- R6: Trigger hits after the first one in a session do not change the count.
- R7: `stop` high during a session suppresses the write in that cycle and ends the session at that edge, whether or not the trigger countdown has run out.
- R8: `last_addr` holds the address of the most recently written byte. It does not change while no write occurs.
- R9: With `read_n` low and no session open, `mem_addr` shows a read pointer. The pointer starts at 0 after `init` and advances by one, with wrap, one edge after each rising edge of `rclk`. Rising edges of `rclk` during a session are ignored.
- R10: `delay_sel` is sampled on the trigger sample. Changing it later in the session has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| init | input | 1 | synchronous re-initialize, active high |
| arm | input | 1 | open a capture session |
| stop | input | 1 | manual end of session |
| smp_en | input | 1 | one-cycle sample strobe |
| trig | input | 1 | trigger qualifier hit for this sample |
| delay_sel | input | 3 | post-trigger length code |
| read_n | input | 1 | read mode select, active low |
| rclk | input | 1 | host read step strobe |
| mem_addr | output | 15 | memory address (write or read) |
| mem_we | output | 1 | memory write enable |
| write_n | output | 1 | low while a session is open |
| last_addr | output | 15 | address of the last stored byte |

## Verification
The bench counts the writes that follow the trigger for all eight length codes. A countdown that is off by one, or a wrong top value, would close the session one byte early or late. Repeated trigger hits and a late change of the length code are applied. A design that reloads the countdown would stretch the session. A full lap of 32768 writes checks that the address wraps, and that a stop in the same cycle as a strobe stores nothing. Read strobes are sent during capture and afterwards, so a pointer that also moved during capture would show a nonzero start.

// File: rtl/capctl.sv
module capctl #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          arm,
  input  logic          stop,
  input  logic          smp_en,
  input  logic          trig,
  input  logic [2:0]    delay_sel,
  input  logic          read_n,
  input  logic          rclk,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          write_n,
  output logic [AW-1:0] last_addr
);

  typedef enum logic [1:0] {S_IDLE, S_CAP, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] waddr, rptr, cnt;
  logic          tseen, rclk_q;
  logic          idle, cap, rd_mode, rise, hit;

  function automatic logic [AW-1:0] post_len(input logic [2:0] c);
    case (c)
      3'd0:    post_len = AW'(1);
      3'd7:    post_len = '1;
      default: post_len = AW'(32'd1 << (2 * 32'(c) + 2));
    endcase
  endfunction

  assign idle    = (st == S_IDLE);
  assign cap     = (st == S_CAP);
  assign mem_we  = cap & smp_en & ~stop & ~init;
  assign write_n = ~cap;
  assign rd_mode = ~read_n & ~cap;
  assign rise    = rclk & ~rclk_q;
  assign hit     = mem_we & trig & ~tseen;
  assign mem_addr = rd_mode ? rptr : waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      waddr     <= '0;
      rptr      <= '0;
      cnt       <= '0;
      tseen     <= 1'b0;
      last_addr <= '0;
      rclk_q    <= 1'b0;
    end else begin
      rclk_q <= rclk;
      if (init) begin
        st        <= S_IDLE;
        waddr     <= '0;
        rptr      <= '0;
        cnt       <= '0;
        tseen     <= 1'b0;
        last_addr <= '0;
      end else begin
        if (rd_mode && rise) rptr <= rptr + 1'b1;
        case (st)
          S_IDLE: if (arm) st <= S_CAP;
          S_CAP: begin
            if (stop) begin
              st <= S_DONE;
            end else if (mem_we) begin
              waddr     <= waddr + 1'b1;
              last_addr <= waddr;
              if (hit) begin
                tseen <= 1'b1;
                cnt   <= post_len(delay_sel);
              end else if (tseen) begin
                cnt <= cnt - 1'b1;
                if (cnt == AW'(1)) st <= S_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module capctl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init,
  input logic          arm,
  input logic          stop,
  input logic          read_n,
  input logic          idle,
  input logic          mem_we,
  input logic          write_n,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] last_addr
);

  a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (write_n && !mem_we && last_addr == '0));

  a_r2_arm_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && idle && !init) |=> !write_n);

  a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !init) |=> (!read_n || mem_addr == AW'($past(mem_addr) + 1'b1)));

  a_r4_we_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !write_n);

  a_r7_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !write_n && !init) |=> write_n);

  a_r8_last_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we && !init) |=> $stable(last_addr));

endmodule

bind capctl capctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .arm(arm), .stop(stop),
  .read_n(read_n), .idle(idle), .mem_we(mem_we), .write_n(write_n),
  .mem_addr(mem_addr), .last_addr(last_addr)
);

// File: tb/test_capctl.sv
module test_capctl;
  localparam int AW = 15;

  logic          clk = 0, rst_n = 0, init = 0, arm = 0, stop = 0;
  logic          smp_en = 0, trig = 0, read_n = 1, rclk = 0;
  logic [2:0]    delay_sel = 0;
  logic [AW-1:0] mem_addr, last_addr;
  logic          mem_we, write_n;
  int total = 0, bad = 0;
  logic          w;
  logic [AW-1:0] a;

  capctl #(.AW(AW)) i_capctl (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_init();
    init = 1; @(negedge clk); init = 0;
  endtask

  task automatic do_arm();
    arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic samp(input logic t);
    smp_en = 1; trig = t; #1;
    w = mem_we; a = mem_addr;
    @(negedge clk); smp_en = 0; trig = 0;
  endtask

  task automatic t_reset();
    do_init(); #1;
    chk(write_n === 1'b1, "R1 write_n", int'(write_n), 1);
    chk(mem_addr === '0, "R1 mem_addr", int'(mem_addr), 0);
    chk(last_addr === '0, "R1 last_addr", int'(last_addr), 0);
    smp_en = 1; #1;
    chk(mem_we === 1'b0, "R4 idle no write", int'(mem_we), 0);
    @(negedge clk); smp_en = 0;
  endtask

  task automatic t_basic();
    do_init(); do_arm();
    chk(write_n === 1'b0, "R2 arm opens", int'(write_n), 0);
    samp(0);
    chk(w === 1'b1 && a == 0, "R3 first write addr", int'(a), 0);
    #1 chk(mem_we === 1'b0, "R3 no strobe no write", int'(mem_we), 0);
    @(negedge clk);
    samp(0);
    chk(w === 1'b1 && a == 1, "R3 second write addr", int'(a), 1);
    #1 chk(last_addr == 1, "R8 last addr", int'(last_addr), 1);
    repeat (3) @(negedge clk);
    chk(last_addr == 1, "R8 held without writes", int'(last_addr), 1);
    stop = 1; @(negedge clk); stop = 0;
    chk(write_n === 1'b1, "R7 stop closes", int'(write_n), 1);
  endtask

  task automatic t_post(input logic [2:0] code, input int n_exp);
    int n = 0;
    do_init(); delay_sel = code; do_arm();
    repeat (3) samp(0);
    samp(1);
    while (!write_n && n < 40000) begin
      samp(0);
      if (w) n++;
    end
    chk(n == n_exp, $sformatf("R5 post count code %0d", code), n, n_exp);
  endtask

  task automatic t_retrig();
    int n = 0;
    do_init(); delay_sel = 3'd1; do_arm();
    samp(1);
    while (!write_n && n < 100) begin
      samp(1);
      if (w) n++;
    end
    chk(n == 16, "R6 later triggers ignored", n, 16);
  endtask

  task automatic t_sel_change();
    int n = 0;
    do_init(); delay_sel = 3'd1; do_arm();
    samp(1);
    delay_sel = 3'd7;
    while (!write_n && n < 100) begin
      samp(0);
      if (w) n++;
    end
    chk(n == 16, "R10 select sampled at trigger", n, 16);
  endtask

  task automatic t_stop();
    do_init(); delay_sel = 3'd7; do_arm();
    samp(1);
    repeat (5) samp(0);
    stop = 1; smp_en = 1; #1;
    chk(mem_we === 1'b0, "R7 stop blocks write", int'(mem_we), 0);
    @(negedge clk); stop = 0; smp_en = 0;
    chk(write_n === 1'b1, "R7 stop overrides count", int'(write_n), 1);
    chk(last_addr == 5, "R8 last addr after stop", int'(last_addr), 5);
    smp_en = 1; #1;
    chk(mem_we === 1'b0, "R4 done no write", int'(mem_we), 0);
    @(negedge clk); smp_en = 0;
    do_arm();
    chk(write_n === 1'b1, "R2 arm ignored when done", int'(write_n), 1);
  endtask

  task automatic t_wrap();
    do_init(); do_arm();
    repeat (32767) samp(0);
    #1 chk(mem_addr == 32767 && last_addr == 32766, "R3 top address", int'(mem_addr), 32767);
    samp(0);
    chk(a == 32767 && w, "R3 write at top", int'(a), 32767);
    #1 chk(mem_addr == 0, "R3 wrap to zero", int'(mem_addr), 0);
    @(negedge clk);
    samp(0);
    chk(a == 0 && w, "R3 write after wrap", int'(a), 0);
    stop = 1; @(negedge clk); stop = 0;
    chk(last_addr == 0, "R8 last addr after wrap", int'(last_addr), 0);
  endtask

  task automatic t_read();
    do_init(); do_arm();
    repeat (2) begin
      rclk = 1; @(negedge clk); rclk = 0; @(negedge clk);
    end
    repeat (4) samp(0);
    stop = 1; @(negedge clk); stop = 0;
    read_n = 0; #1;
    chk(mem_addr == 0, "R9 pointer ignores capture strobes", int'(mem_addr), 0);
    @(negedge clk);
    repeat (3) begin
      rclk = 1; @(negedge clk); rclk = 0; @(negedge clk);
    end
    chk(mem_addr == 3, "R9 pointer steps", int'(mem_addr), 3);
    read_n = 1; #1;
    chk(mem_addr == 4, "R9 write addr restored", int'(mem_addr), 4);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    t_reset();
    t_basic();
    t_post(3'd0, 1);
    t_post(3'd1, 16);
    t_post(3'd2, 64);
    t_post(3'd3, 256);
    t_post(3'd4, 1024);
    t_post(3'd5, 4096);
    t_post(3'd6, 16384);
    t_post(3'd7, 32767);
    t_retrig();
    t_sel_change();
    t_stop();
    t_wrap();
    t_read();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule